// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block produces the bit clock and the frame-sync signal that a serial audio port needs when it is the clock master. An input clock is divided down to form the bit clock. A second counter steps once per bit clock, and from it the block forms a frame-sync pulse. The number of bit clocks per frame and the number of bit clocks the pulse stays active are each set by their own field. For I2S or left-justified framing, set the width to half the frame. For DSP-style framing, use a width of zero, which gives a one-bit pulse. A one-cycle strobe marks the start of every frame.

The divider, period and width fields are copied into shadow registers when the block starts and again at each frame boundary. A change made in the middle of a frame therefore changes only the next frame. When the enable rises, both counters restart. When the enable is low, the outputs rest at their inactive levels.

For slave operation, a bypass sends external bit-clock and frame-sync inputs straight through the polarity stage. In this mode the internal counters stay idle and no strobe is produced.

Top module: `audio_srg`

## Requirements
- R1: After reset, with `en` low, `bclk` equals `bclk_inv`, `fsync` equals the inverse of `fs_inv`, and `frame_start` is 0.
- R2: With a divide field D greater than 0, the bit clock has a period of D+1 input cycles. It is high for the first ceil((D+1)/2) cycles of each period when `bclk_inv` is 0.
- R3: With a divide field of 0, the running bit clock follows the input clock: high while `clk` is high and low while `clk` is low, when `bclk_inv` is 0.
- R4: The period field P (12 bits) gives P+1 bit clocks per frame, so `frame_start` repeats every (P+1)*(D+1) input cycles.
- R5: The width field W (8 bits) keeps frame sync active for min(W,P)+1 bit clocks from the start of each frame. A width of 0 gives a one-bit pulse, and W >= P keeps it active all frame.
- R6: `fs_inv` = 0 makes the frame sync active low and `fs_inv` = 1 makes it active high. `bclk_inv` = 1 inverts the bit clock.
- R7: In the first cycle after `en` rises in master mode, `frame_start` is 1, frame sync is active, and the bit clock is in its high (rising-edge) phase.
- R8: While `en` is low, `frame_start` stays 0 and both clock outputs rest at their inactive levels.
- R9: A change to the period field during a frame does not alter that frame's length. It takes effect from the next frame boundary.
- R10: With `slave` = 1, `bclk` = `ext_bclk` XOR `bclk_inv`, `fsync` = `ext_fs` XOR `fs_inv`, and `frame_start` is 0.
- R11: `frame_start` coincides with the start of a bit-clock high phase, so the bit clock is at its non-inverted high level during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided down |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; a rising edge restarts both counters |
| slave | input | 1 | 1 selects the external clock and frame-sync bypass |
| div_in | input | 8 | Divide field; bit clock = clk/(div_in+1) |
| per_in | input | 12 | Bit clocks per frame minus one |
| wid_in | input | 8 | Frame-sync active width in bit clocks minus one |
| bclk_inv | input | 1 | Invert bit-clock polarity |
| fs_inv | input | 1 | 1 makes frame sync active high |
| ext_bclk | input | 1 | External bit clock for slave mode |
| ext_fs | input | 1 | External frame sync for slave mode |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| frame_start | output | 1 | One-cycle strobe at each frame start |

## Verification
Every master-mode result comes from a register, so each result appears one input cycle after the edge that causes it. The restart strobe is sampled in the first cycle after the edge that sees `en` high, and that cycle is counted as index 0. From index 0, the next strobe is expected at index (P+1)*(D+1), bit-clock highs are counted over indices 0 to D, and frame-sync active cycles are counted over one full frame. The slave bypass and the divide-by-1 case are combinational. The bench samples them within the same clock phase, once a few nanoseconds after the rising edge and again after the falling edge.

// File: rtl/audio_srg_pkg.sv
package audio_srg_pkg;
   localparam int SRG_DIV_W = 8;
   localparam int SRG_PER_W = 12;
   localparam int SRG_WID_W = 8;

   typedef enum logic {
      POL_NORMAL = 1'b0,
      POL_INVERT = 1'b1
   } srg_pol_e;

   typedef struct packed {
      logic bclk_q;
      logic fs_act;
      logic fstart_q;
   } srg_core_t;
endpackage

// File: rtl/audio_srg_bitclk.sv
module audio_srg_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic             run_q,
   input  logic [DIV_W-1:0] div_cur,
   output logic             bclk_q,
   output logic             bit_end
);
   localparam int HW = DIV_W + 1;

   logic [DIV_W-1:0] dcnt;
   logic [DIV_W-1:0] dcnt_n;
   logic [HW-1:0]    half;

   assign half    = HW'(({1'b0, div_cur} + HW'(2)) >> 1);
   assign bit_end = run_q && (dcnt == div_cur);
   assign dcnt_n  = (dcnt == div_cur) ? '0 : dcnt + DIV_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dcnt   <= '0;
         bclk_q <= 1'b0;
      end else if (restart) begin
         dcnt   <= '0;
         bclk_q <= 1'b1;
      end else if (!active) begin
         dcnt   <= '0;
         bclk_q <= 1'b0;
      end else begin
         dcnt   <= dcnt_n;
         bclk_q <= ({1'b0, dcnt_n} < half);
      end
   end
endmodule

// File: rtl/audio_srg_frame.sv
module audio_srg_frame #(
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic             bit_end,
   input  logic [PER_W-1:0] per_cur,
   input  logic [WID_W-1:0] wid_cur,
   output logic             fs_act,
   output logic             fstart_q,
   output logic             frame_end
);
   localparam int CW = (PER_W > WID_W) ? PER_W : WID_W;

   logic [PER_W-1:0] fcnt;
   logic [PER_W-1:0] fcnt_n;

   assign frame_end = bit_end && (fcnt == per_cur);
   assign fcnt_n    = (fcnt == per_cur) ? '0 : fcnt + PER_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt     <= '0;
         fs_act   <= 1'b0;
         fstart_q <= 1'b0;
      end else if (restart) begin
         fcnt     <= '0;
         fs_act   <= 1'b1;
         fstart_q <= 1'b1;
      end else if (!active) begin
         fcnt     <= '0;
         fs_act   <= 1'b0;
         fstart_q <= 1'b0;
      end else if (bit_end) begin
         fcnt     <= fcnt_n;
         fs_act   <= (CW'(fcnt_n) <= CW'(wid_cur));
         fstart_q <= frame_end;
      end else begin
         fstart_q <= 1'b0;
      end
   end
endmodule

// File: rtl/audio_srg_pins.sv
module audio_srg_pins (
   input  logic clk,
   input  logic slave,
   input  logic run_q,
   input  logic div_zero,
   input  logic bclk_q,
   input  logic fs_act,
   input  logic fstart_q,
   input  logic ext_bclk,
   input  logic ext_fs,
   input  logic bclk_inv,
   input  logic fs_inv,
   output logic bclk,
   output logic fsync,
   output logic frame_start
);
   logic bclk_m;
   logic fs_m;

   always_comb begin
      if (slave) begin
         bclk_m = ext_bclk;
         fs_m   = ext_fs;
      end else begin
         bclk_m = (run_q && div_zero) ? clk : bclk_q;
         fs_m   = ~fs_act;
      end
   end

   assign bclk        = bclk_m ^ bclk_inv;
   assign fsync       = fs_m ^ fs_inv;
   assign frame_start = fstart_q & ~slave;
endmodule

// File: rtl/audio_srg.sv
module audio_srg
   import audio_srg_pkg::*;
#(
   parameter int DIV_W = SRG_DIV_W,
   parameter int PER_W = SRG_PER_W,
   parameter int WID_W = SRG_WID_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             slave,
   input  logic [DIV_W-1:0] div_in,
   input  logic [PER_W-1:0] per_in,
   input  logic [WID_W-1:0] wid_in,
   input  logic             bclk_inv,
   input  logic             fs_inv,
   input  logic             ext_bclk,
   input  logic             ext_fs,
   output logic             bclk,
   output logic             fsync,
   output logic             frame_start
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("audio_srg: DIV_W out of range");
      end
      if (PER_W < 1 || PER_W > 16) begin : g_bad_per
         $error("audio_srg: PER_W out of range");
      end
      if (WID_W < 1 || WID_W > PER_W) begin : g_bad_wid
         $error("audio_srg: WID_W must be 1..PER_W");
      end
   endgenerate

   logic             active;
   logic             run_q;
   logic             restart;
   logic             bit_end;
   logic             frame_end;
   logic [DIV_W-1:0] div_q;
   logic [PER_W-1:0] per_q;
   logic [WID_W-1:0] wid_q;
   srg_core_t        core;

   assign active  = en & ~slave;
   assign restart = active & ~run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         div_q <= '0;
         per_q <= '0;
         wid_q <= '0;
      end else begin
         run_q <= active;
         if (restart || frame_end) begin
            div_q <= div_in;
            per_q <= per_in;
            wid_q <= wid_in;
         end
      end
   end

   audio_srg_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .restart (restart),
      .run_q   (run_q),
      .div_cur (div_q),
      .bclk_q  (core.bclk_q),
      .bit_end (bit_end)
   );

   audio_srg_frame #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .restart   (restart),
      .bit_end   (bit_end),
      .per_cur   (per_q),
      .wid_cur   (wid_q),
      .fs_act    (core.fs_act),
      .fstart_q  (core.fstart_q),
      .frame_end (frame_end)
   );

   audio_srg_pins u_pins (
      .clk         (clk),
      .slave       (slave),
      .run_q       (run_q),
      .div_zero    (div_q == '0),
      .bclk_q      (core.bclk_q),
      .fs_act      (core.fs_act),
      .fstart_q    (core.fstart_q),
      .ext_bclk    (ext_bclk),
      .ext_fs      (ext_fs),
      .bclk_inv    (bclk_inv),
      .fs_inv      (fs_inv),
      .bclk        (bclk),
      .fsync       (fsync),
      .frame_start (frame_start)
   );
endmodule

// File: rtl/audio_srg_chk.sv
module audio_srg_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             slave,
   input logic             bclk_inv,
   input logic             fs_inv,
   input logic             bclk,
   input logic             fsync,
   input logic             frame_start,
   input logic [DIV_W-1:0] div_cur
);
   // R7: rising enable in master mode restarts with a strobe
   a_r7_restart_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(en) && !slave && !$past(slave)) |=> (frame_start || slave));

   // R8: enable held low keeps outputs idle
   a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en) && !slave) |-> (!frame_start && (fsync == !fs_inv) && (bclk == bclk_inv)));

   // R5: frame sync is active during the strobe
   a_r5_active_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !slave) |-> (fsync == fs_inv));

   // R11: strobe coincides with a bit-clock high phase
   a_r11_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !slave && (div_cur != '0)) |-> (bclk != bclk_inv));
endmodule

bind audio_srg audio_srg_chk #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .slave       (slave),
   .bclk_inv    (bclk_inv),
   .fs_inv      (fs_inv),
   .bclk        (bclk),
   .fsync       (fsync),
   .frame_start (frame_start),
   .div_cur     (div_q)
);

// File: tb/audio_srg_bench.sv
module audio_srg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        slave = 1'b0;
   logic [7:0]  div_in = '0;
   logic [11:0] per_in = '0;
   logic [7:0]  wid_in = '0;
   logic        bclk_inv = 1'b0;
   logic        fs_inv = 1'b0;
   logic        ext_bclk = 1'b0;
   logic        ext_fs = 1'b0;
   logic        bclk;
   logic        fsync;
   logic        frame_start;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   audio_srg u_audio_srg (
      .clk(clk), .rst_n(rst_n), .en(en), .slave(slave),
      .div_in(div_in), .per_in(per_in), .wid_in(wid_in),
      .bclk_inv(bclk_inv), .fs_inv(fs_inv),
      .ext_bclk(ext_bclk), .ext_fs(ext_fs),
      .bclk(bclk), .fsync(fsync), .frame_start(frame_start)
   );

   localparam int NV = 6;
   localparam int VD [NV] = '{1, 2, 3, 0, 4, 5};
   localparam int VP [NV] = '{3, 7, 4, 5, 2, 9};
   localparam int VW [NV] = '{1, 3, 0, 2, 5, 4};
   localparam int VB [NV] = '{0, 0, 1, 0, 0, 1};
   localparam int VF [NV] = '{0, 1, 0, 0, 1, 1};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic start(input int d, input int p, input int w, input int b, input int f);
      @(negedge clk);
      en = 1'b0; slave = 1'b0;
      div_in = 8'(d); per_in = 12'(p); wid_in = 8'(w);
      bclk_inv = b[0]; fs_inv = f[0];
      @(negedge clk);
      @(negedge clk);
      en = 1'b1;
   endtask

   task automatic run_vec(input int d, input int p, input int w, input int b, input int f);
      int flen, fs_cnt, hi_cnt, st_cnt, wmin;
      flen = (p + 1) * (d + 1);
      wmin = (w < p) ? w : p;
      fs_cnt = 0; hi_cnt = 0; st_cnt = 0;
      start(d, p, w, b, f);
      for (int k = 0; k <= flen; k++) begin
         tick();
         if (k == 0) begin
            chk(frame_start == 1'b1, "R7 strobe after enable", int'(frame_start), 1);
            chk(bclk == ~b[0], "R7/R11 bclk high at start", int'(bclk), int'(~b[0]));
            chk(fsync == f[0], "R6 fsync active level", int'(fsync), f);
         end
         if (k < flen) begin
            if (fsync == f[0]) fs_cnt++;
            if (frame_start) st_cnt++;
            if (k <= d && (bclk ^ b[0])) hi_cnt++;
         end else begin
            chk(frame_start == 1'b1, "R4 next strobe at frame length", int'(frame_start), 1);
         end
      end
      chk(st_cnt == 1, "R4 single strobe per frame", st_cnt, 1);
      chk(fs_cnt == (wmin + 1) * (d + 1), "R5 fsync active cycles", fs_cnt, (wmin + 1) * (d + 1));
      if (d > 0)
         chk(hi_cnt == (d + 2) / 2, "R2 bclk high cycles", hi_cnt, (d + 2) / 2);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(bclk == 1'b0, "R1 bclk at reset", int'(bclk), 0);
      chk(fsync == 1'b1, "R1 fsync at reset", int'(fsync), 1);
      chk(frame_start == 1'b0, "R1 strobe at reset", int'(frame_start), 0);

      for (int v = 0; v < NV; v++)
         run_vec(VD[v], VP[v], VW[v], VB[v], VF[v]);

      // R3 divide-by-1 follows input clock
      start(0, 3, 1, 0, 0);
      repeat (3) tick();
      chk(bclk == 1'b1, "R3 bclk high with clk high", int'(bclk), 1);
      @(negedge clk); #2;
      chk(bclk == 1'b0, "R3 bclk low with clk low", int'(bclk), 0);

      // R9 period change mid-frame applies at next boundary
      start(1, 3, 1, 0, 0);
      for (int k = 0; k <= 20; k++) begin
         tick();
         if (k == 2) begin
            @(negedge clk);
            per_in = 12'd5;
         end
         if (k == 8)  chk(frame_start == 1'b1, "R9 old frame length kept", int'(frame_start), 1);
         if (k == 16) chk(frame_start == 1'b0, "R9 no strobe at old spacing", int'(frame_start), 0);
         if (k == 20) chk(frame_start == 1'b1, "R9 new frame length used", int'(frame_start), 1);
      end

      // R8 idle with enable low
      @(negedge clk);
      en = 1'b0; bclk_inv = 1'b1; fs_inv = 1'b0;
      repeat (2) tick();
      for (int k = 0; k < 6; k++) begin
         chk(frame_start == 1'b0, "R8 no strobe when disabled", int'(frame_start), 0);
         chk(bclk == 1'b1 && fsync == 1'b1, "R8 idle levels", int'({bclk, fsync}), 3);
         tick();
      end

      // R10 slave bypass
      @(negedge clk);
      slave = 1'b1; en = 1'b1; bclk_inv = 1'b0; fs_inv = 1'b0;
      ext_bclk = 1'b1; ext_fs = 1'b0;
      tick();
      chk(bclk == 1'b1 && fsync == 1'b0, "R10 slave pass normal", int'({bclk, fsync}), 2);
      chk(frame_start == 1'b0, "R10 no strobe in slave", int'(frame_start), 0);
      @(negedge clk);
      bclk_inv = 1'b1; fs_inv = 1'b1;
      #2;
      chk(bclk == 1'b0 && fsync == 1'b1, "R10 slave pass inverted", int'({bclk, fsync}), 1);
      ext_bclk = 1'b0; ext_fs = 1'b1;
      #1;
      chk(bclk == 1'b1 && fsync == 1'b0, "R10 slave follows inputs", int'({bclk, fsync}), 2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule